// File: doc/BRIEF.md
# Debug-Monitor Return Sequencer

This block performs the hardware side of leaving a debug monitor. On a start command it takes a snapshot of the current link register (the saved return address), of the previous-context word and of the debug save-area pointer. It then fetches four words, one at a time, from the save area through a word-wide read port that uses a valid/ready handshake. When the last word arrives, it publishes every result in the same cycle.

The published results are:

- The new program counter, which is the snapshot link value with bit 0 cleared.
- The interrupt-enable bit and the current priority number, both taken from the previous-context snapshot.
- The reloaded previous-context word, status word, stack register and link register.

The status word leaves on its own write-strobe pair so that the core can route it through its normal status-write path. A feature input, which is sampled at start, selects whether a one-cycle clear pulse for the debug trap control register is issued together with the commit.

Instruction decode and memory arbitration are outside the block. The core treats the single-cycle `done_o`/`reg_we_o` strobe as the moment at which all of its architectural registers change together.

Top module: `dbg_return_seq`

## Requirements
- R1: After reset, busy_o, done_o, rd_valid_o, reg_we_o, psw_we_o and trapctl_clr_o are 0 and all register outputs are 0.
- R2: At commit, pc_o equals the link_i value sampled at start with bit 0 forced to 0, even though link_o is reloaded in the same commit.
- R3: Exactly four reads are issued, at save_ptr, save_ptr+4, save_ptr+8 and save_ptr+12 (word-aligned byte addresses, in that order), with at most one read outstanding and no request while idle.
- R4: The four returned words, in read order, appear on ctx_o, psw_data_o, stack_o and link_o respectively.
- R5: At commit, ie_o equals bit 23 and ccpn_o equals bits 31:24 of prev_ctx_i as sampled at start, not of the reloaded word.
- R6: The status word is delivered only through psw_we_o/psw_data_o, with psw_we_o high for exactly the commit cycle.
- R7: No register output changes except in the single cycle where reg_we_o is high, and all of them change together in that cycle.
- R8: busy_o rises the cycle after an accepted start and stays high through the done_o cycle; done_o is a one-cycle pulse, after which busy_o is 0.
- R9: A start received while busy is ignored: no extra read, and the inputs presented with it do not affect the results.
- R10: trapctl_clr_o pulses in the commit cycle only when clr_trapctl_en_i was 1 at start.
- R11: While rd_valid_o is high and rd_ready_i is low, rd_valid_o stays high and rd_addr_o is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a return (ignored while busy) |
| save_ptr_i | input | AW | Base byte address of the 4-word save area |
| link_i | input | DW | Current link register (return address) |
| prev_ctx_i | input | DW | Current previous-context word |
| clr_trapctl_en_i | input | 1 | Feature: clear debug trap control at commit |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_valid_o | output | 1 | Read request valid |
| rd_addr_o | output | AW | Read request byte address |
| rd_ready_i | input | 1 | Read request accepted |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | DW | Read data |
| reg_we_o | output | 1 | Commit strobe for all register outputs |
| pc_o | output | DW | New program counter |
| ie_o | output | 1 | New interrupt enable |
| ccpn_o | output | PCPN_W | New current priority number |
| ctx_o | output | DW | Reloaded previous-context word |
| stack_o | output | DW | Reloaded stack register |
| link_o | output | DW | Reloaded link register |
| psw_we_o | output | 1 | Status-word write strobe |
| psw_data_o | output | DW | Status-word write data |
| trapctl_clr_o | output | 1 | Clear pulse for the debug trap control register |

## Verification
If the slot index is wrong, the read addresses or the word ordering go wrong. That shows up on rd_addr_o at the handshake of the bad read, and on the swapped outputs at the single commit cycle. If the snapshot is lost or is taken late, pc_o, ie_o and ccpn_o follow inputs that were changed mid-sequence, which becomes visible at commit. A state machine that commits early, or in more than one step, moves a register output while reg_we_o is low, and the per-cycle stability checks catch that in the very cycle it happens.

// File: rtl/dbgret_pkg.sv
package dbgret_pkg;
   localparam int unsigned SLOTS = 4;
   localparam int unsigned IDX_W = 2;
   typedef logic [IDX_W-1:0] slot_idx_t;

   localparam int unsigned SLOT_CTX = 0;
   localparam int unsigned SLOT_PSW = 1;
   localparam int unsigned SLOT_STK = 2;
   localparam int unsigned SLOT_LNK = 3;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2,
      ST_DONE = 2'd3
   } dr_state_e;
endpackage

// File: rtl/dbgret_ctrl.sv
module dbgret_ctrl
   import dbgret_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start_i,
   input  logic      req_ready_i,
   input  logic      rsp_valid_i,
   output slot_idx_t idx_o,
   output logic      take_snap_o,
   output logic      cap_o,
   output logic      commit_o,
   output logic      req_valid_o,
   output logic      busy_o,
   output logic      done_o
);
   dr_state_e state_q;
   slot_idx_t idx_q;
   logic      last_slot;

   assign last_slot   = (idx_q == slot_idx_t'(SLOTS - 1));
   assign take_snap_o = (state_q == ST_IDLE) && start_i;
   assign cap_o       = (state_q == ST_WAIT) && rsp_valid_i;
   assign commit_o    = cap_o && last_slot;
   assign req_valid_o = (state_q == ST_REQ);
   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = (state_q == ST_DONE);
   assign idx_o       = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_REQ;
                  idx_q   <= '0;
               end
            end
            ST_REQ: begin
               if (req_ready_i) state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rsp_valid_i) begin
                  if (last_slot) begin
                     state_q <= ST_DONE;
                  end else begin
                     idx_q   <= idx_q + slot_idx_t'(1);
                     state_q <= ST_REQ;
                  end
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dbgret_rdport.sv
module dbgret_rdport
   import dbgret_pkg::*;
#(
   parameter int unsigned AW          = 32,
   parameter int unsigned WORD_BYTES  = 4,
   parameter bit          FORCE_ALIGN = 1'b1
) (
   input  logic [AW-1:0] base_i,
   input  slot_idx_t     idx_i,
   output logic [AW-1:0] addr_o
);
   localparam int unsigned OFS_W = $clog2(WORD_BYTES);

   logic [AW-1:0] base_eff;
   logic [AW-1:0] step;

   if (FORCE_ALIGN) begin : g_align
      assign base_eff = base_i & ~AW'(WORD_BYTES - 1);
   end else begin : g_raw
      assign base_eff = base_i;
   end

   assign step   = AW'(idx_i) << OFS_W;
   assign addr_o = base_eff + step;
endmodule

// File: rtl/dbgret_stage.sv
module dbgret_stage
   import dbgret_pkg::*;
#(
   parameter int unsigned AW       = 32,
   parameter int unsigned DW       = 32,
   parameter int unsigned PIE_BIT  = 23,
   parameter int unsigned PCPN_LSB = 24,
   parameter int unsigned PCPN_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_snap_i,
   input  logic              cap_i,
   input  logic              commit_i,
   input  slot_idx_t         idx_i,
   input  logic [DW-1:0]     rsp_data_i,
   input  logic [AW-1:0]     save_ptr_i,
   input  logic [DW-1:0]     link_i,
   input  logic [DW-1:0]     prev_ctx_i,
   input  logic              feat_i,
   output logic [AW-1:0]     base_snap_o,
   output logic              feat_snap_o,
   output logic [DW-1:0]     pc_o,
   output logic              ie_o,
   output logic [PCPN_W-1:0] ccpn_o,
   output logic [DW-1:0]     ctx_o,
   output logic [DW-1:0]     psw_o,
   output logic [DW-1:0]     stack_o,
   output logic [DW-1:0]     link_o
);
   logic [DW-1:0]     pc_snap;
   logic              ie_snap;
   logic [PCPN_W-1:0] ccpn_snap;
   logic [DW-1:0]     word_w [SLOTS];
   logic              unused_bits;

   assign unused_bits = ^{prev_ctx_i, link_i[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_snap     <= '0;
         ie_snap     <= 1'b0;
         ccpn_snap   <= '0;
         base_snap_o <= '0;
         feat_snap_o <= 1'b0;
      end else if (take_snap_i) begin
         pc_snap     <= {link_i[DW-1:1], 1'b0};
         ie_snap     <= prev_ctx_i[PIE_BIT];
         ccpn_snap   <= prev_ctx_i[PCPN_LSB +: PCPN_W];
         base_snap_o <= save_ptr_i;
         feat_snap_o <= feat_i;
      end
   end

   for (genvar g = 0; g < SLOTS - 1; g++) begin : g_slot
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else if (cap_i && (idx_i == slot_idx_t'(g))) q <= rsp_data_i;
      end
      assign word_w[g] = q;
   end
   assign word_w[SLOTS-1] = rsp_data_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_o    <= '0;
         ie_o    <= 1'b0;
         ccpn_o  <= '0;
         ctx_o   <= '0;
         psw_o   <= '0;
         stack_o <= '0;
         link_o  <= '0;
      end else if (commit_i) begin
         pc_o    <= pc_snap;
         ie_o    <= ie_snap;
         ccpn_o  <= ccpn_snap;
         ctx_o   <= word_w[SLOT_CTX];
         psw_o   <= word_w[SLOT_PSW];
         stack_o <= word_w[SLOT_STK];
         link_o  <= word_w[SLOT_LNK];
      end
   end
endmodule

// File: rtl/dbg_return_seq.sv
module dbg_return_seq
   import dbgret_pkg::*;
#(
   parameter int unsigned AW          = 32,
   parameter int unsigned DW          = 32,
   parameter int unsigned PIE_BIT     = 23,
   parameter int unsigned PCPN_LSB    = 24,
   parameter int unsigned PCPN_W      = 8,
   parameter bit          FORCE_ALIGN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [AW-1:0]     save_ptr_i,
   input  logic [DW-1:0]     link_i,
   input  logic [DW-1:0]     prev_ctx_i,
   input  logic              clr_trapctl_en_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              rd_valid_o,
   output logic [AW-1:0]     rd_addr_o,
   input  logic              rd_ready_i,
   input  logic              rsp_valid_i,
   input  logic [DW-1:0]     rsp_data_i,
   output logic              reg_we_o,
   output logic [DW-1:0]     pc_o,
   output logic              ie_o,
   output logic [PCPN_W-1:0] ccpn_o,
   output logic [DW-1:0]     ctx_o,
   output logic [DW-1:0]     stack_o,
   output logic [DW-1:0]     link_o,
   output logic              psw_we_o,
   output logic [DW-1:0]     psw_data_o,
   output logic              trapctl_clr_o
);
   localparam int unsigned WORD_BYTES = DW / 8;

   if ((DW % 8) != 0 || DW < 16) begin : g_bad_dw
      $error("dbg_return_seq: DW must be a multiple of 8 and at least 16");
   end
   if (PIE_BIT >= DW || (PCPN_LSB + PCPN_W) > DW || PCPN_W == 0) begin : g_bad_field
      $error("dbg_return_seq: priority/enable fields fall outside DW");
   end
   if (AW < 8) begin : g_bad_aw
      $error("dbg_return_seq: AW too small for a 4-word save area");
   end

   slot_idx_t     idx;
   logic          take_snap, cap, commit;
   logic [AW-1:0] base_snap;
   logic          feat_snap;

   dbgret_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .req_ready_i (rd_ready_i),
      .rsp_valid_i (rsp_valid_i),
      .idx_o       (idx),
      .take_snap_o (take_snap),
      .cap_o       (cap),
      .commit_o    (commit),
      .req_valid_o (rd_valid_o),
      .busy_o      (busy_o),
      .done_o      (done_o)
   );

   dbgret_rdport #(
      .AW          (AW),
      .WORD_BYTES  (WORD_BYTES),
      .FORCE_ALIGN (FORCE_ALIGN)
   ) u_rdport (
      .base_i (base_snap),
      .idx_i  (idx),
      .addr_o (rd_addr_o)
   );

   dbgret_stage #(
      .AW       (AW),
      .DW       (DW),
      .PIE_BIT  (PIE_BIT),
      .PCPN_LSB (PCPN_LSB),
      .PCPN_W   (PCPN_W)
   ) u_stage (
      .clk         (clk),
      .rst_n       (rst_n),
      .take_snap_i (take_snap),
      .cap_i       (cap),
      .commit_i    (commit),
      .idx_i       (idx),
      .rsp_data_i  (rsp_data_i),
      .save_ptr_i  (save_ptr_i),
      .link_i      (link_i),
      .prev_ctx_i  (prev_ctx_i),
      .feat_i      (clr_trapctl_en_i),
      .base_snap_o (base_snap),
      .feat_snap_o (feat_snap),
      .pc_o        (pc_o),
      .ie_o        (ie_o),
      .ccpn_o      (ccpn_o),
      .ctx_o       (ctx_o),
      .psw_o       (psw_data_o),
      .stack_o     (stack_o),
      .link_o      (link_o)
   );

   assign reg_we_o      = done_o;
   assign psw_we_o      = done_o;
   assign trapctl_clr_o = done_o & feat_snap;
endmodule

// File: rtl/dbgret_chk.sv
module dbgret_chk #(
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          rd_valid_o,
   input logic [AW-1:0] rd_addr_o,
   input logic          rd_ready_i,
   input logic          reg_we_o,
   input logic          psw_we_o,
   input logic          trapctl_clr_o,
   input logic [DW-1:0] pc_o,
   input logic [DW-1:0] ctx_o,
   input logic [DW-1:0] stack_o,
   input logic [DW-1:0] link_o,
   input logic [DW-1:0] psw_data_o
);
   p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));

   p_idle_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !rd_valid_o);

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !busy_o);

   p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && start_i |=> busy_o);

   p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !done_o |=> busy_o);

   p_regs_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_we_o |-> $stable(pc_o) && $stable(ctx_o) && $stable(stack_o)
                    && $stable(link_o));

   p_psw_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !psw_we_o |-> $stable(psw_data_o));

   p_clr_in_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      trapctl_clr_o |-> reg_we_o && busy_o);

   p_pc_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we_o |-> !pc_o[0]);
endmodule

bind dbg_return_seq dbgret_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .busy_o        (busy_o),
   .done_o        (done_o),
   .rd_valid_o    (rd_valid_o),
   .rd_addr_o     (rd_addr_o),
   .rd_ready_i    (rd_ready_i),
   .reg_we_o      (reg_we_o),
   .psw_we_o      (psw_we_o),
   .trapctl_clr_o (trapctl_clr_o),
   .pc_o          (pc_o),
   .ctx_o         (ctx_o),
   .stack_o       (stack_o),
   .link_o        (link_o),
   .psw_data_o    (psw_data_o)
);

// File: tb/tb_dbg_return_seq.sv
module tb_dbg_return_seq;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [AW-1:0] save_ptr_i = '0;
   logic [DW-1:0] link_i = '0;
   logic [DW-1:0] prev_ctx_i = '0;
   logic          clr_trapctl_en_i = 1'b0;
   logic          busy_o, done_o, rd_valid_o, reg_we_o, ie_o, psw_we_o, trapctl_clr_o;
   logic [AW-1:0] rd_addr_o;
   logic          rd_ready_i = 1'b0;
   logic          rsp_valid_i = 1'b0;
   logic [DW-1:0] rsp_data_i = '0;
   logic [DW-1:0] pc_o, ctx_o, stack_o, link_o, psw_data_o;
   logic [7:0]    ccpn_o;

   int            nchecks = 0;
   int            nfail = 0;
   int            cyc = 0;
   int            ready_mode = 0;
   int            nreq = 0;
   logic [31:0]   mem [16];
   logic [AW-1:0] addr_log [16];

   dbg_return_seq dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .save_ptr_i(save_ptr_i),
      .link_i(link_i), .prev_ctx_i(prev_ctx_i), .clr_trapctl_en_i(clr_trapctl_en_i),
      .busy_o(busy_o), .done_o(done_o), .rd_valid_o(rd_valid_o), .rd_addr_o(rd_addr_o),
      .rd_ready_i(rd_ready_i), .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
      .reg_we_o(reg_we_o), .pc_o(pc_o), .ie_o(ie_o), .ccpn_o(ccpn_o), .ctx_o(ctx_o),
      .stack_o(stack_o), .link_o(link_o), .psw_we_o(psw_we_o), .psw_data_o(psw_data_o),
      .trapctl_clr_o(trapctl_clr_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc        <= cyc + 1;
      rd_ready_i <= (ready_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
      rsp_valid_i <= 1'b0;
      if (rd_valid_o && rd_ready_i) begin
         rsp_valid_i      <= 1'b1;
         rsp_data_i       <= mem[rd_addr_o[5:2]];
         addr_log[nreq % 16] <= rd_addr_o;
         nreq             <= nreq + 1;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      nchecks++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One return; leaves the caller at the negedge where done_o is seen.
   task automatic run(input logic [31:0] base, input logic [31:0] lnk,
                      input logic [31:0] pctx, input bit feat, input bit poke);
      logic [31:0] p_pc, p_ctx, p_stk, p_lnk;
      bit          moved;
      moved = 1'b0;
      p_pc = pc_o; p_ctx = ctx_o; p_stk = stack_o; p_lnk = link_o;
      @(negedge clk);
      save_ptr_i = base; link_i = lnk; prev_ctx_i = pctx; clr_trapctl_en_i = feat;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o == 1'b1, "R8 busy after start", {31'd0, busy_o}, 32'd1);
      for (int k = 0; k < 200; k++) begin
         if (done_o) break;
         if (pc_o != p_pc || ctx_o != p_ctx || stack_o != p_stk || link_o != p_lnk)
            moved = 1'b1;
         if (poke && k == 2) begin
            start_i = 1'b1; save_ptr_i = 32'h0000_0020;
            link_i = 32'hFFFF_FFFF; prev_ctx_i = 32'h0000_0000; clr_trapctl_en_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
      end
      start_i = 1'b0;
      check(!moved, "R7 outputs held before commit", {31'd0, moved}, 32'd0);
      check(done_o && reg_we_o, "R8 done reached", {31'd0, done_o}, 32'd1);
   endtask

   task automatic check_result(input logic [31:0] base, input logic [31:0] lnk,
                               input logic [31:0] pctx, input bit feat, input int n0);
      int i0;
      i0 = int'(base[5:2]);
      check(pc_o == {lnk[31:1], 1'b0}, "R2 pc", pc_o, {lnk[31:1], 1'b0});
      check(ie_o == pctx[23], "R5 ie", {31'd0, ie_o}, {31'd0, pctx[23]});
      check(ccpn_o == pctx[31:24], "R5 ccpn", {24'd0, ccpn_o}, {24'd0, pctx[31:24]});
      check(ctx_o == mem[i0 % 16], "R4 ctx", ctx_o, mem[i0 % 16]);
      check(psw_we_o && psw_data_o == mem[(i0 + 1) % 16], "R6 psw",
            psw_data_o, mem[(i0 + 1) % 16]);
      check(stack_o == mem[(i0 + 2) % 16], "R4 stack", stack_o, mem[(i0 + 2) % 16]);
      check(link_o == mem[(i0 + 3) % 16], "R4 link", link_o, mem[(i0 + 3) % 16]);
      check(trapctl_clr_o == feat, "R10 trap clear", {31'd0, trapctl_clr_o}, {31'd0, feat});
      check(nreq - n0 == 4, "R3 read count", nreq - n0, 32'd4);
      for (int j = 0; j < 4; j++)
         check(addr_log[(n0 + j) % 16] == base + 32'(4 * j), "R3 read address",
               addr_log[(n0 + j) % 16], base + 32'(4 * j));
      @(negedge clk);
      check(!done_o && !busy_o, "R8 done single pulse", {30'd0, done_o, busy_o}, 32'd0);
      check(!psw_we_o && !trapctl_clr_o, "R6 R10 strobes drop",
            {30'd0, psw_we_o, trapctl_clr_o}, 32'd0);
   endtask

   task automatic t_reset();
      check(!busy_o && !done_o && !rd_valid_o, "R1 control idle",
            {29'd0, busy_o, done_o, rd_valid_o}, 32'd0);
      check(!reg_we_o && !psw_we_o && !trapctl_clr_o, "R1 strobes low",
            {29'd0, reg_we_o, psw_we_o, trapctl_clr_o}, 32'd0);
      check(pc_o == 0 && ctx_o == 0 && stack_o == 0 && link_o == 0 && psw_data_o == 0
            && ccpn_o == 0 && !ie_o, "R1 registers zero", pc_o | link_o, 32'd0);
   endtask

   task automatic t_basic();
      int n0;
      ready_mode = 0; n0 = nreq;
      run(32'h0000_0020, 32'h8000_1235, 32'hA580_0000, 1'b0, 1'b0);
      check_result(32'h0000_0020, 32'h8000_1235, 32'hA580_0000, 1'b0, n0);
   endtask

   task automatic t_stall_feature();
      int n0;
      ready_mode = 1; n0 = nreq;
      run(32'h0000_0034, 32'h1000_0011, 32'h3C7F_FFFF, 1'b1, 1'b0);
      check_result(32'h0000_0034, 32'h1000_0011, 32'h3C7F_FFFF, 1'b1, n0);
   endtask

   task automatic t_busy_start();
      int n0;
      ready_mode = 0; n0 = nreq;
      run(32'h0000_0000, 32'h0000_4447, 32'h5A80_1234, 1'b0, 1'b1);
      check_result(32'h0000_0000, 32'h0000_4447, 32'h5A80_1234, 1'b0, n0);
      repeat (4) @(negedge clk);
      check(nreq - n0 == 4 && !busy_o, "R9 start while busy ignored", nreq - n0, 32'd4);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 32'hC0DE_0000 + 32'(i) * 32'h0101_0001;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_basic();
      t_stall_feature();
      t_busy_start();
      t_basic();
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      nchecks++;
      nfail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end
endmodule